// File: doc/BRIEF.md
# Redundant Reference Selection Controller

This block is the control-register front end of a unit that feeds a PLL from one of two redundant reference clocks. A host writes configuration fields through a byte-wide register port with a per-bit write mask: PLL operating mode, loop-filter bandwidth, reference frequency, a manual primary/secondary choice, a hardware auto-switch enable with its trigger choice, and a reference-align control bit. The block drives these settings to the clocking hardware. It also turns each rising transition of the align bit into a one-cycle align pulse.

The block owns the select output that names the active reference. Software can load that output directly. When hardware switching is enabled, the block can also move it to the other reference on an alarm. The trigger is either a new loss of the active reference or PLL entry into holdover. A switch happens only while the other reference is healthy. The active reference reads back in its own bit, separate from the manual select bit, so software can see that an automatic switch took place.

Top module: `refsel_ctrl`

## Requirements
- R1: After reset all fields are zero, the active reference is primary (0), the align pulse is low, and every address reads 0x00.
- R2: A write changes only the bits whose `wr_mask` bit is 1. Masked-off bits of a register keep their value.
- R3: Address 0 holds the following fields: bit 7 hardware switch enable, bit 6 trigger select (1 = PLL holdover, 0 = lost clock), bits 5:4 PLL mode (00 normal, 01 holdover, 10 free-run), bit 3 align control, and bit 2 filter (1 = 6 Hz, 0 = 12 Hz). Bits 1:0 read as 0. The fields drive the matching outputs.
- R4: A write that would leave the mode field at 11 leaves the mode field unchanged.
- R5: Address 1 holds bit 0, the manual select (0 primary, 1 secondary), and bit 1, the frequency (0 = 8 kHz, 1 = 19.44 MHz). Bit 3 reads the active reference and ignores writes. Other bits read 0. Addresses 2 and up read 0x00.
- R6: A write to address 1 with mask bit 0 set loads the active reference with the written bit 0, in the same cycle as the manual bit.
- R7: `align_pulse` is high for exactly one cycle after a write that takes the stored align bit from 0 to 1. Writing 1 while the bit is already 1 gives no pulse.
- R8: When switching is enabled with the lost-clock trigger, a rising edge of the active reference's loss alarm toggles the active reference. A loss of the inactive reference has no effect.
- R9: When switching is enabled with the holdover trigger, a rising edge of `pll_holdover` toggles the active reference. In this mode, loss alarms do not switch.
- R10: An automatic switch is suppressed while the loss alarm of the other reference is high.
- R11: When hardware switching is disabled, alarms never change the active reference.
- R12: If a manual select write and a switch trigger fall in the same cycle, the written value wins.
- R13: An automatic switch does not change the manual select bit as read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rdata | output | 8 | Combinational readback of `addr` |
| lost_pri | input | 1 | Primary reference loss alarm (level) |
| lost_sec | input | 1 | Secondary reference loss alarm (level) |
| pll_holdover | input | 1 | PLL holdover indication (level) |
| active_ref | output | 1 | Active reference select (0 primary, 1 secondary) |
| pll_mode | output | 2 | PLL mode field |
| filter_narrow | output | 1 | 1 selects the 6 Hz loop filter |
| ref_freq_hi | output | 1 | 1 selects the 19.44 MHz reference |
| align_pulse | output | 1 | One-cycle reference-align pulse |

## Verification
The hardest states to reach are the ones where a trigger edge arrives while the other reference's alarm is already held high. The same applies when a trigger edge and a manual select write land in the same clock edge. The stimulus drives both loss alarms as levels and keeps one asserted across a later trigger edge. It also raises the holdover alarm in the same cycle as a write to address 1. This shows that suppression and write priority come from the present alarm levels, not from stale edges.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int REG_W   = 8;
    localparam int MODE_W  = 2;
    localparam int NUM_ALM = 3;   // lost_pri, lost_sec, holdover

    // address 0 field positions
    localparam int B_HWEN  = 7;
    localparam int B_TRIG  = 6;
    localparam int B_MODEH = 5;
    localparam int B_MODEL = 4;
    localparam int B_ALIGN = 3;
    localparam int B_FILT  = 2;
    // address 1 field positions
    localparam int B_MSEL  = 0;
    localparam int B_FREQ  = 1;
    localparam int B_ACT   = 3;

    localparam logic [MODE_W-1:0] MODE_BAD = 2'b11;

    typedef struct packed {
        logic               hw_en;
        logic               trig_hold;
        logic [MODE_W-1:0]  mode;
        logic               align;
        logic               filt;
        logic               freq;
        logic               man_sel;
        logic               active;
        logic               pulse;
        logic [NUM_ALM-1:0] alm_prev;
    } state_t;
endpackage

// File: rtl/rsc_rise_det.sv
module rsc_rise_det #(
    parameter int N = 3
) (
    input  logic [N-1:0] alm_i,
    input  logic [N-1:0] prev_i,
    output logic [N-1:0] rise_o
);
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] = alm_i[i] & ~prev_i[i];
    end
endmodule

// File: rtl/rsc_switch_eval.sv
module rsc_switch_eval (
    input  logic       hw_en,
    input  logic       trig_hold,
    input  logic       active,
    input  logic [1:0] lost_rise,
    input  logic [1:0] lost_lvl,
    input  logic       hold_rise,
    output logic       toggle
);
    logic trig_hit;
    logic other_bad;

    always_comb begin
        trig_hit  = trig_hold ? hold_rise : lost_rise[active];
        other_bad = lost_lvl[~active];
        toggle    = hw_en & trig_hit & ~other_bad;
    end
endmodule

// File: rtl/rsc_readback.sv
module rsc_readback
    import refsel_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  state_t            st,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(0)) begin
            rdata[B_HWEN]          = st.hw_en;
            rdata[B_TRIG]          = st.trig_hold;
            rdata[B_MODEH:B_MODEL] = st.mode;
            rdata[B_ALIGN]         = st.align;
            rdata[B_FILT]          = st.filt;
        end else if (addr == ADDR_W'(1)) begin
            rdata[B_MSEL] = st.man_sel;
            rdata[B_FREQ] = st.freq;
            rdata[B_ACT]  = st.active;
        end
    end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        wr_mask,
    output logic [7:0]        rdata,
    input  logic              lost_pri,
    input  logic              lost_sec,
    input  logic              pll_holdover,
    output logic              active_ref,
    output logic [1:0]        pll_mode,
    output logic              filter_narrow,
    output logic              ref_freq_hi,
    output logic              align_pulse
);
    state_t st_d, st_q;

    logic [NUM_ALM-1:0] alm_now;
    logic [NUM_ALM-1:0] alm_rise;
    logic               toggle;
    logic               wr_cfg;
    logic               wr_sel;
    logic [REG_W-1:0]   merged0;
    logic [REG_W-1:0]   merged1;
    logic [REG_W-1:0]   cur0;
    logic [REG_W-1:0]   cur1;

    assign alm_now = {pll_holdover, lost_sec, lost_pri};

    rsc_rise_det #(.N(NUM_ALM)) u_rise (
        .alm_i  (alm_now),
        .prev_i (st_q.alm_prev),
        .rise_o (alm_rise)
    );

    rsc_switch_eval u_sw (
        .hw_en     (st_q.hw_en),
        .trig_hold (st_q.trig_hold),
        .active    (st_q.active),
        .lost_rise (alm_rise[1:0]),
        .lost_lvl  ({lost_sec, lost_pri}),
        .hold_rise (alm_rise[2]),
        .toggle    (toggle)
    );

    rsc_readback #(.ADDR_W(ADDR_W)) u_rb (
        .addr  (addr),
        .st    (st_q),
        .rdata (rdata)
    );

    always_comb begin
        wr_cfg = wr_en && (addr == ADDR_W'(0));
        wr_sel = wr_en && (addr == ADDR_W'(1)) && wr_mask[B_MSEL];

        cur0 = '0;
        cur0[B_HWEN]          = st_q.hw_en;
        cur0[B_TRIG]          = st_q.trig_hold;
        cur0[B_MODEH:B_MODEL] = st_q.mode;
        cur0[B_ALIGN]         = st_q.align;
        cur0[B_FILT]          = st_q.filt;
        cur1 = '0;
        cur1[B_MSEL] = st_q.man_sel;
        cur1[B_FREQ] = st_q.freq;

        merged0 = (wdata & wr_mask) | (cur0 & ~wr_mask);
        merged1 = (wdata & wr_mask) | (cur1 & ~wr_mask);

        st_d          = st_q;
        st_d.pulse    = 1'b0;
        st_d.alm_prev = alm_now;

        if (toggle) begin
            st_d.active = ~st_q.active;
        end

        if (wr_cfg) begin
            st_d.hw_en     = merged0[B_HWEN];
            st_d.trig_hold = merged0[B_TRIG];
            st_d.filt      = merged0[B_FILT];
            st_d.align     = merged0[B_ALIGN];
            st_d.pulse     = merged0[B_ALIGN] & ~st_q.align;
            if (merged0[B_MODEH:B_MODEL] != MODE_BAD) begin
                st_d.mode = merged0[B_MODEH:B_MODEL];
            end
        end

        if (wr_en && (addr == ADDR_W'(1))) begin
            st_d.man_sel = merged1[B_MSEL];
            st_d.freq    = merged1[B_FREQ];
        end

        if (wr_sel) begin
            st_d.active = wdata[B_MSEL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_ref    = st_q.active;
    assign pll_mode      = st_q.mode;
    assign filter_narrow = st_q.filt;
    assign ref_freq_hi   = st_q.freq;
    assign align_pulse   = st_q.pulse;

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_pulse |=> !align_pulse);

    // R4
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_mode != MODE_BAD);

    // R11
    hw_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.hw_en && !wr_sel) |=> $stable(active_ref));

    // R10
    other_lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hw_en && (st_q.active ? lost_pri : lost_sec) && !wr_sel)
            |=> $stable(active_ref));

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (active_ref == $past(wdata[B_MSEL])));

    // R3
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(0)) |-> (rdata[1:0] == 2'b00));
endmodule

// File: tb/refsel_ctrl_tb.sv
module refsel_ctrl_tb;
    localparam int CLK_PER = 10;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    wr_mask = '0;
    logic [7:0]    rdata;
    logic          lost_pri = 1'b0;
    logic          lost_sec = 1'b0;
    logic          pll_holdover = 1'b0;
    logic          active_ref;
    logic [1:0]    pll_mode;
    logic          filter_narrow;
    logic          ref_freq_hi;
    logic          align_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [7:0] rd;
        logic       act;
        logic       pls;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];

    always #(CLK_PER/2) clk = ~clk;

    refsel_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wr_mask(wr_mask), .rdata(rdata),
        .lost_pri(lost_pri), .lost_sec(lost_sec), .pll_holdover(pll_holdover),
        .active_ref(active_ref), .pll_mode(pll_mode),
        .filter_narrow(filter_narrow), .ref_freq_hi(ref_freq_hi),
        .align_pulse(align_pulse)
    );

    // monitor: compare queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (rdata !== e.rd || active_ref !== e.act || align_pulse !== e.pls) begin
                    fails++;
                    $display("FAIL %s: rdata=%02h act=%0b pulse=%0b expected rdata=%02h act=%0b pulse=%0b",
                             t, rdata, active_ref, align_pulse, e.rd, e.act, e.pls);
                end
            end
        end
    end

    // driver tasks, always entered on a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [7:0] m);
        wr_en = 1'b1; addr = a; wdata = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic chk(input logic [AW-1:0] a, input logic [7:0] rd,
                       input logic act, input logic pls, input string tag);
        exp_t e;
        addr = a;
        e.rd = rd; e.act = act; e.pls = pls;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 8'h00, 0, 0, "R1 addr0");
        chk(1, 8'h00, 0, 0, "R1 addr1");
        chk(6, 8'h00, 0, 0, "R1 addr6");

        // R3 field layout: mode=01 filter=1
        wr(0, 8'h14, 8'hFF);
        chk(0, 8'h14, 0, 0, "R3 mode holdover filter 6Hz");
        // R2 masked write of mode only, low bits ignored
        wr(0, 8'h23, 8'h30);
        chk(0, 8'h24, 0, 0, "R2 masked mode free-run");
        // R4 reserved mode value
        wr(0, 8'h30, 8'h30);
        chk(0, 8'h24, 0, 0, "R4 mode 11 ignored");

        // R7 align pulse
        wr(0, 8'h08, 8'h08);
        chk(0, 8'h2C, 0, 1, "R7 align pulse high");
        chk(0, 8'h2C, 0, 0, "R7 align pulse one cycle");
        wr(0, 8'h08, 8'h08);
        chk(0, 8'h2C, 0, 0, "R7 no pulse when already set");
        wr(0, 8'h00, 8'h08);
        chk(0, 8'h24, 0, 0, "R2 align cleared");

        // R5 R6 select register
        wr(1, 8'hFF, 8'hFF);
        chk(1, 8'h0B, 1, 0, "R6 manual load secondary");
        wr(1, 8'h00, 8'h01);
        chk(1, 8'h02, 0, 0, "R5 freq kept manual primary");
        chk(5, 8'h00, 0, 0, "R5 unused address");

        // R11 switching disabled
        lost_pri = 1'b1; step();
        chk(1, 8'h02, 0, 0, "R11 no switch when disabled");
        lost_pri = 1'b0; step();

        // R8 lost-clock trigger
        wr(0, 8'h80, 8'hC0);
        chk(0, 8'hA4, 0, 0, "R3 hw enable lost trigger");
        lost_pri = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R8 R13 switch to secondary, manual bit kept");
        lost_sec = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R10 primary lost blocks switch");
        lost_pri = 1'b0; lost_sec = 1'b0; step();
        lost_pri = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R8 inactive loss ignored");
        lost_pri = 1'b0; step();
        lost_sec = 1'b1; step();
        chk(1, 8'h02, 0, 0, "R8 switch back to primary");
        lost_sec = 1'b0; step();

        // R9 holdover trigger
        wr(0, 8'hC0, 8'hC0);
        chk(0, 8'hE4, 0, 0, "R3 holdover trigger");
        pll_holdover = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R9 holdover switch");
        pll_holdover = 1'b0; step();
        lost_sec = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R9 loss ignored in holdover mode");
        lost_sec = 1'b0; lost_pri = 1'b1; step();
        pll_holdover = 1'b1; step();
        chk(1, 8'h0A, 1, 0, "R10 holdover blocked by primary loss");
        pll_holdover = 1'b0; lost_pri = 1'b0; step();

        // R12 write and trigger in same cycle
        pll_holdover = 1'b1;
        wr(1, 8'h01, 8'h01);
        chk(1, 8'h0B, 1, 0, "R12 write wins over trigger");
        pll_holdover = 1'b0; step();

        repeat (2) step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule